// File: doc/BRIEF.md
# Atomic clock source and half-integer divider switch

This block generates a root clock by picking one of several input clocks and dividing it by a ratio that may be a whole or a half-whole number. Software works through two 32-bit words on a small synchronous register bus that runs on an always-on register clock. The configuration word is a shadow: writing a new source number and divider code there changes nothing at the output. Software then sets the update bit in the command word. The block then retires the old setting and brings up the new one as a single step, so that no output cycle ever mixes the old source with the new divider, or the new source with the old divider.

Each input clock has its own divider path, built from flops on both edges of that input. The path that is running is asked to stop, and it parks its output low at the end of a full output period. Only then is the new source and divider pair committed. The path for the new source loads the divider code while it is idle and starts at the beginning of a fresh period. The update bit drops once the register domain sees the new path running.

A dirty flag shows that the shadow differs from the setting in use. A root-off flag shows that no path is driving the output.

Top module: `clk_srcdiv_switch`

## Requirements
- R1: After reset the command word reads 0 for the update bit and the dirty flag, the configuration word reads 0, and the output runs from source 0 undivided.
- R2: The command word is at address 0x0 and the configuration word at 0x4. The source field is at bits [9:8] and the divider code at bits [4:0]; other configuration bits read 0; any other address reads 0; read data is registered, one cycle after the address.
- R3: With divider code c, the output period is the selected input period times max(c+1,2)/2, so codes 0 and 1 both give divide by 1.
- R4: With P = max(c+1,2), the output stays high for floor(P/2) half-periods of the selected input in every period.
- R5: Command bit 4 (dirty) reads 1 exactly when the shadow source or divider differs from the pair in use.
- R6: Writing 1 to command bit 0 starts an update; the bit reads 1 until the new pair is running and then clears by itself; writing 0 there changes nothing.
- R7: With the selected inputs running, an update completes within 1500 register-bus reads.
- R8: Source and divider are committed together: every output high pulse during a switch has the width of either the old pair or the new pair, and at most one input path runs at a time.
- R9: Command bit 31 (root off) reads 1 while no input path drives the output, for example between stopping the old path and starting the new one, and reads 0 once the output runs.
- R10: A configuration write while an update is pending goes only to the shadow and sets the dirty flag. The update in flight uses the pair latched when it was requested, and the new write takes effect only at the next update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk | input | 1 | Always-on register and control clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_clk | input | 2**SRC_W | Candidate input clocks |
| clk_out | output | 1 | Divided, switched output clock |

## Verification
A bad phase counter or half-period threshold inside a divider path shows up in the first full output period measured after an update, as a wrong period or a wrong high time. A commit that lets the divider code reach a path that is still running produces a high pulse of a width belonging to neither setting, and the pulse monitor flags it at that pulse. A lost handshake leaves the update bit set, so the poll bound catches it within 1500 reads. A shadow that is not latched at request time shows as the wrong rate or a wrong dirty flag right after the update.

// File: rtl/mdsw_pkg.sv
package mdsw_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_STOP, ST_START} sw_state_t;

  localparam int unsigned CMD_OFS   = 0;
  localparam int unsigned CFG_OFS   = 4;
  localparam int unsigned UPD_BIT   = 0;
  localparam int unsigned DIRTY_BIT = 4;
  localparam int unsigned OFF_BIT   = 31;
endpackage

// File: rtl/mdsw_sync.sv
module mdsw_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end

  assign q = s2;
endmodule

// File: rtl/mdsw_halfdiv.sv
// One input clock path: a dual-edge divider with a stop and start gate at period boundaries.
module mdsw_halfdiv #(
  parameter int DIV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] code_i,
  output logic             run_o,
  output logic             clk_o
);
  localparam int PW = DIV_W + 1;  // period in half-cycles
  localparam int CW = PW + 1;

  logic [1:0]    rst_pipe;
  logic          rst_s;
  logic          en_s;
  logic          run;
  logic          pt;               // posedge toggle flop
  logic          nt;               // negedge toggle flop
  logic [PW-1:0] per_q;            // half-cycles per output period
  logic [PW-1:0] pc;               // half-cycle index of the next posedge
  logic [PW-1:0] per_new;
  logic [PW-1:0] half;
  logic [PW-1:0] start_pc;
  logic [PW-1:0] pc_nxt;
  logic [PW-1:0] ni;
  logic [CW-1:0] pc_inc;
  logic          lvl_p;
  logic          lvl_n;

  always_ff @(posedge clk_i) rst_pipe <= {rst_pipe[0], rst_i};
  assign rst_s = rst_pipe[1];

  mdsw_sync #(.W(1)) u_en_sync (
    .clk (clk_i),
    .rst (rst_s),
    .d   (en_i),
    .q   (en_s)
  );

  always_comb begin
    per_new  = (code_i < DIV_W'(2)) ? PW'(2) : (PW'(code_i) + PW'(1));
    half     = per_q >> 1;
    start_pc = (per_new == PW'(2)) ? '0 : PW'(2);
    pc_inc   = {1'b0, pc} + CW'(2);
    pc_nxt   = (pc_inc >= {1'b0, per_q}) ? PW'(pc_inc - {1'b0, per_q}) : PW'(pc_inc);
    ni       = (pc == '0) ? (per_q - PW'(1)) : (pc - PW'(1));
    lvl_p    = (pc < half);
    lvl_n    = run && (ni < half);
  end

  always_ff @(posedge clk_i) begin
    if (rst_s) begin
      run   <= 1'b0;
      pc    <= '0;
      per_q <= PW'(2);
      pt    <= 1'b0;
    end else if (!run) begin
      if (en_s) begin
        run   <= 1'b1;
        per_q <= per_new;
        pc    <= start_pc;
        pt    <= ~nt;
      end else begin
        pt <= nt;
      end
    end else if (pc == '0 && !en_s) begin
      run <= 1'b0;
      pt  <= nt;
    end else begin
      pt <= lvl_p ^ nt;
      pc <= pc_nxt;
    end
  end

  always_ff @(negedge clk_i) begin
    if (rst_s) nt <= 1'b0;
    else       nt <= lvl_n ^ pt;
  end

  assign clk_o = pt ^ nt;
  assign run_o = run;

  AST_STOP_PARKS_LOW: assert property (@(posedge clk_i) disable iff (rst_s)
    $fell(run) |-> (pt == nt)); // R8
endmodule

// File: rtl/mdsw_ctrl.sv
// Register domain: shadow configuration, commit sequencing, and the update handshake.
module mdsw_ctrl
  import mdsw_pkg::*;
#(
  parameter int SRC_W   = 2,
  parameter int DIV_W   = 5,
  parameter int SRC_LSB = 8,
  parameter int DIV_LSB = 0,
  parameter int ADDR_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_wr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [(1<<SRC_W)-1:0]   run_i,
  output logic [(1<<SRC_W)-1:0]   en_o,
  output logic [DIV_W-1:0]        div_o
);
  localparam int NSRC = 1 << SRC_W;

  sw_state_t        state, state_d;
  logic [SRC_W-1:0] sh_src, pd_src, act_src, act_src_d;
  logic [DIV_W-1:0] sh_div, pd_div, act_div, act_div_d;
  logic             upd_q, upd_d;
  logic [NSRC-1:0]  en_q, en_d, ack_s;
  logic [31:0]      rdata_q, rd_d, cmd_word, cfg_word;
  logic             wr_cfg, wr_cmd, upd_req, dirty, root_off;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata;

  mdsw_sync #(.W(NSRC)) u_ack_sync (
    .clk (clk),
    .rst (rst),
    .d   (run_i),
    .q   (ack_s)
  );

  always_comb begin
    wr_cfg  = bus_wr && (bus_addr == ADDR_W'(CFG_OFS));
    wr_cmd  = bus_wr && (bus_addr == ADDR_W'(CMD_OFS));
    upd_req = wr_cmd && bus_wdata[UPD_BIT] && (state == ST_IDLE);
  end

  always_comb begin
    state_d   = state;
    act_src_d = act_src;
    act_div_d = act_div;
    upd_d     = upd_q;
    case (state)
      ST_IDLE: if (upd_req) begin
        state_d = ST_STOP;
        upd_d   = 1'b1;
      end
      ST_STOP: if (ack_s == '0) begin
        state_d   = ST_START;
        act_src_d = pd_src;
        act_div_d = pd_div;
      end
      ST_START: if (ack_s[act_src]) begin
        state_d = ST_IDLE;
        upd_d   = 1'b0;
      end
      default: state_d = ST_IDLE;
    endcase
    en_d = '0;
    if (state_d != ST_STOP) en_d[act_src_d] = 1'b1;
  end

  always_comb begin
    dirty    = (sh_src != act_src) || (sh_div != act_div);
    root_off = (ack_s == '0);
    cmd_word = '0;
    cmd_word[UPD_BIT]   = upd_q;
    cmd_word[DIRTY_BIT] = dirty;
    cmd_word[OFF_BIT]   = root_off;
    cfg_word = '0;
    cfg_word[SRC_LSB +: SRC_W] = sh_src;
    cfg_word[DIV_LSB +: DIV_W] = sh_div;
    if (bus_addr == ADDR_W'(CMD_OFS))      rd_d = cmd_word;
    else if (bus_addr == ADDR_W'(CFG_OFS)) rd_d = cfg_word;
    else                                   rd_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      sh_src  <= '0;
      sh_div  <= '0;
      pd_src  <= '0;
      pd_div  <= '0;
      act_src <= '0;
      act_div <= '0;
      upd_q   <= 1'b0;
      en_q    <= '0;
      rdata_q <= '0;
    end else begin
      state   <= state_d;
      act_src <= act_src_d;
      act_div <= act_div_d;
      upd_q   <= upd_d;
      en_q    <= en_d;
      rdata_q <= rd_d;
      if (wr_cfg) begin
        sh_src <= bus_wdata[SRC_LSB +: SRC_W];
        sh_div <= bus_wdata[DIV_LSB +: DIV_W];
      end
      if (upd_req) begin
        pd_src <= sh_src;
        pd_div <= sh_div;
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign en_o      = en_q;
  assign div_o     = act_div;

  AST_ONE_PATH_RUNS: assert property (@(posedge clk) disable iff (rst)
    $countones(ack_s) <= 1); // R8
  AST_COMMIT_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!$stable(act_src) || !$stable(act_div)) |-> ($past(ack_s) == '0)); // R8
  AST_DONE_MEANS_RUNNING: assert property (@(posedge clk) disable iff (rst)
    $fell(upd_q) |-> ack_s[act_src]); // R6
  AST_BUSY_NOT_DIRTY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $rose(upd_q) |=> upd_q); // R6
endmodule

// File: rtl/clk_srcdiv_switch.sv
module clk_srcdiv_switch #(
  parameter int SRC_W   = 2,
  parameter int DIV_W   = 5,
  parameter int SRC_LSB = 8,
  parameter int DIV_LSB = 0,
  parameter int ADDR_W  = 4
) (
  input  logic                  reg_clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [(1<<SRC_W)-1:0] src_clk,
  output logic                  clk_out
);
  localparam int NSRC = 1 << SRC_W;

  logic [NSRC-1:0]  run_v;
  logic [NSRC-1:0]  en_v;
  logic [NSRC-1:0]  clk_v;
  logic [DIV_W-1:0] div_w;

  mdsw_ctrl #(
    .SRC_W   (SRC_W),
    .DIV_W   (DIV_W),
    .SRC_LSB (SRC_LSB),
    .DIV_LSB (DIV_LSB),
    .ADDR_W  (ADDR_W)
  ) u_ctrl (
    .clk       (reg_clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .run_i     (run_v),
    .en_o      (en_v),
    .div_o     (div_w)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_path
    mdsw_halfdiv #(.DIV_W(DIV_W)) u_div (
      .clk_i  (src_clk[g]),
      .rst_i  (rst),
      .en_i   (en_v[g]),
      .code_i (div_w),
      .run_o  (run_v[g]),
      .clk_o  (clk_v[g])
    );
  end

  assign clk_out = |clk_v;
endmodule

// File: tb/clk_srcdiv_switch_tb.sv
`timescale 1ns/1ps
module clk_srcdiv_switch_tb;
  localparam logic [3:0] A_CMD = 4'h0;
  localparam logic [3:0] A_CFG = 4'h4;

  real tsrc [4] = '{8.0, 12.0, 20.0, 28.0};

  logic        reg_clk = 0;
  logic        rst = 1;
  logic [3:0]  bus_addr = 0;
  logic        bus_wr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [3:0]  src_clk = 0;
  logic        clk_out;

  int  n_chk = 0, n_fail = 0, bad_pulse = 0;
  bit  mon_on = 0, off_seen = 0;
  real hi_old = 4.0, hi_new = 4.0, t_rise = 0.0, pw = 0.0;
  int  cur_s = 0, cur_c = 0;

  always #10 reg_clk = ~reg_clk;
  always #4  src_clk[0] = ~src_clk[0];
  always #6  src_clk[1] = ~src_clk[1];
  always #10 src_clk[2] = ~src_clk[2];
  always #14 src_clk[3] = ~src_clk[3];

  clk_srcdiv_switch u_dut (
    .reg_clk   (reg_clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_clk   (src_clk),
    .clk_out   (clk_out)
  );

  function automatic real rabs(real x);
    return (x < 0.0) ? -x : x;
  endfunction

  function automatic real exp_per(int s, int c);
    int p;
    p = (c < 2) ? 2 : c + 1;
    return tsrc[s] * p / 2.0;
  endfunction

  function automatic real exp_hi(int s, int c);
    int p;
    p = (c < 2) ? 2 : c + 1;
    return tsrc[s] / 2.0 * (p / 2);
  endfunction

  function automatic logic [31:0] cfgv(int s, int c);
    return (32'(s) << 8) | 32'(c);
  endfunction

  // R8: every high pulse must match the old or the new setting
  always @(posedge clk_out) t_rise = $realtime;
  always @(negedge clk_out) begin
    if (mon_on) begin
      pw = $realtime - t_rise;
      if (rabs(pw - hi_old) > 0.01 && rabs(pw - hi_new) > 0.01) bad_pulse++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge reg_clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge reg_clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge reg_clk);
    bus_addr = a;
    @(negedge reg_clk);
    d = bus_rdata;
  endtask

  task automatic measure(output real per, output real hi);
    real t0, t1, t2;
    @(posedge clk_out);
    @(posedge clk_out); t0 = $realtime;
    @(negedge clk_out); t1 = $realtime;
    @(posedge clk_out); t2 = $realtime;
    per = t2 - t0;
    hi  = t1 - t0;
  endtask

  task automatic run_update();
    logic [31:0] v;
    int n;
    wr(A_CMD, 32'h1);
    rd(A_CMD, v);
    chk(v[0] == 1'b1, "R6", "update bit while pending", real'(v[0]), 1.0);
    n = 0;
    while (v[0] && n < 1500) begin
      rd(A_CMD, v);
      if (v[31]) off_seen = 1;
      n++;
    end
    chk(v[0] == 1'b0, "R7", "update bit cleared within bound", real'(n), 1500.0);
  endtask

  task automatic apply(input int s, input int c);
    logic [31:0] v;
    real per, hi;
    hi_new = exp_hi(s, c);
    wr(A_CFG, cfgv(s, c));
    rd(A_CMD, v);
    chk(v[4] == ((s != cur_s) || (c != cur_c)), "R5", "dirty after shadow write",
        real'(v[4]), real'((s != cur_s) || (c != cur_c)));
    rd(A_CFG, v);
    chk(v == cfgv(s, c), "R2", "config readback", real'(v), real'(cfgv(s, c)));
    run_update();
    rd(A_CMD, v);
    chk(v[4] == 1'b0, "R5", "dirty after commit", real'(v[4]), 0.0);
    chk(v[31] == 1'b0, "R9", "root off after commit", real'(v[31]), 0.0);
    measure(per, hi);
    chk(rabs(per - exp_per(s, c)) < 0.01, "R3", $sformatf("period src %0d code %0d", s, c), per, exp_per(s, c));
    chk(rabs(hi - exp_hi(s, c)) < 0.01, "R4", $sformatf("high time src %0d code %0d", s, c), hi, exp_hi(s, c));
    cur_s = s; cur_c = c;
    hi_old = hi_new;
  endtask

  initial begin
    #3000000;
    chk(1'b0, "WD", "watchdog expired", 0.0, 1.0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    real per, hi;
    repeat (10) @(posedge reg_clk);
    @(negedge reg_clk) rst = 0;

    // R1: reset state
    rd(A_CMD, v);
    chk(v[0] == 1'b0, "R1", "update bit after reset", real'(v[0]), 0.0);
    chk(v[4] == 1'b0, "R1", "dirty after reset", real'(v[4]), 0.0);
    rd(A_CFG, v);
    chk(v == 32'h0, "R1", "config after reset", real'(v), 0.0);
    repeat (20) @(posedge reg_clk);
    measure(per, hi);
    chk(rabs(per - 8.0) < 0.01, "R1", "period after reset", per, 8.0);
    chk(rabs(hi - 4.0) < 0.01, "R1", "high time after reset", hi, 4.0);
    rd(A_CMD, v);
    chk(v[31] == 1'b0, "R9", "root off while running", real'(v[31]), 0.0);
    mon_on = 1;

    // R2: map and field positions
    rd(4'h8, v);
    chk(v == 32'h0, "R2", "unmapped read", real'(v), 0.0);
    wr(A_CFG, 32'hFFFF_FFFF);
    rd(A_CFG, v);
    chk(v == 32'h0000_031F, "R2", "only fields stored", real'(v), real'(32'h31F));
    rd(A_CMD, v);
    chk(v[4] == 1'b1, "R5", "dirty after all-ones write", real'(v[4]), 1.0);

    // R6: writing 0 to the update bit does nothing
    wr(A_CMD, 32'h0);
    rd(A_CMD, v);
    chk(v[0] == 1'b0, "R6", "zero write leaves update bit clear", real'(v[0]), 0.0);
    chk(v[4] == 1'b1, "R6", "zero write leaves shadow pending", real'(v[4]), 1.0);
    measure(per, hi);
    chk(rabs(per - 8.0) < 0.01, "R6", "zero write leaves rate", per, 8.0);
    wr(A_CFG, 32'h0);
    rd(A_CMD, v);
    chk(v[4] == 1'b0, "R5", "dirty after restoring shadow", real'(v[4]), 0.0);

    // R3 R4 R5 R7 R8: sweep every source and divider code
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 32; c++)
        apply(s, c);

    // R10: shadow write while an update is pending
    hi_new = exp_hi(1, 4);
    wr(A_CFG, cfgv(1, 4));
    wr(A_CMD, 32'h1);
    wr(A_CFG, cfgv(2, 7));
    v = 32'h1;
    for (int n = 0; n < 1500 && v[0]; n++) rd(A_CMD, v);
    chk(v[0] == 1'b0, "R7", "first update of pending pair finished", real'(v[0]), 0.0);
    chk(v[4] == 1'b1, "R10", "dirty after write during pending update", real'(v[4]), 1.0);
    measure(per, hi);
    chk(rabs(per - exp_per(1, 4)) < 0.01, "R10", "update used pair latched at request", per, exp_per(1, 4));
    cur_s = 1; cur_c = 4; hi_old = hi_new;
    hi_new = exp_hi(2, 7);
    run_update();
    rd(A_CMD, v);
    chk(v[4] == 1'b0, "R10", "dirty after second update", real'(v[4]), 0.0);
    measure(per, hi);
    chk(rabs(per - exp_per(2, 7)) < 0.01, "R10", "second update applies later write", per, exp_per(2, 7));
    hi_old = hi_new;

    chk(bad_pulse == 0, "R8", "mixed-setting high pulses", real'(bad_pulse), 0.0);
    chk(off_seen, "R9", "root off seen during switches", real'(off_seen), 1.0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule